// File: doc/BRIEF.md
# Iterative Slice-Serial Wide Adder

This block adds two wide operands with one narrow adder. It is not a full-width carry chain. A start request latches both operands. On each of the following cycles, the sequencer selects one narrow slice of each operand, adds them and writes the narrow sum into the matching slice of the result register. Work runs from the least significant slice upward. The carry out of each slice is held in a flop and feeds the next slice.

When the top slice has been written, `done_o` pulses for one cycle. At that point `result_o` and `carry_o` hold the full sum and its final carry, and both stay unchanged until the next accepted start. The block suits places where area matters more than latency, for example a low-rate datapath that needs occasional wide additions.

The operand width must be a multiple of the slice width and larger than it. An addition takes `OP_W/SLICE_W` cycles after the start cycle.

Top module: `iter_adder`

## Requirements
- R1: For a start accepted while idle, on the `done_o` cycle `{carry_o, result_o}` equals the unsigned sum of the operands presented with that start.
- R2: If start is sampled on clock edge t, `done_o` is low after edges t+1 to t+N-1 (N = OP_W/SLICE_W). It is high only after edge t+N and low again after edge t+N+1.
- R3: The carry into the least significant slice is always 0, even when the previous addition ended with `carry_o` = 1.
- R4: A carry produced in one slice is added into the next higher slice, so a carry ripples across every slice boundary (for example 0xFFFFFFFF + 1 gives 0 with carry 1).
- R5: Slices are processed least significant first. After the j-th processing edge, slices 0 to j-1 of `result_o` (slice k is bits k*SLICE_W upward) hold the new sum. Higher slices still hold the previous result.
- R6: A start request while an addition is in progress is ignored. The running addition completes with its own operands and timing, and no extra `done_o` pulse follows.
- R7: Reset (rst_ni low, asynchronous) clears `result_o`, `carry_o` and `done_o` to 0.
- R8: While idle with no start, `result_o` and `carry_o` hold their last values regardless of `a_i` and `b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new addition; accepted only while idle |
| a_i | input | OP_W | First operand, sampled with an accepted start |
| b_i | input | OP_W | Second operand, sampled with an accepted start |
| result_o | output | OP_W | Sum register, filled one slice per cycle |
| carry_o | output | 1 | Registered slice carry; final carry-out on the done cycle |
| done_o | output | 1 | One-cycle pulse after the top slice is written |

## Verification
A wrong slice index or a slice written out of turn shows up on `result_o` after the first processing edge, because partial sums are visible slice by slice as the addition runs. A carry flop that is not cleared at start corrupts the lowest slice of the next sum. A dropped carry shows only where a slice boundary is crossed, and it is seen at `done_o`, N cycles after start. A sequencer that restarts on a second start shifts or duplicates the `done_o` pulse, so that error is visible at the expected done cycle.

// File: rtl/iter_add_pkg.sv
package iter_add_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/slice_mux.sv
module slice_mux #(
  parameter int OP_W    = 32,
  parameter int SLICE_W = 8,
  parameter int N_SLICE = OP_W / SLICE_W,
  parameter int CNT_W   = 2
) (
  input  logic [OP_W-1:0]    vec_i,
  input  logic [CNT_W-1:0]   idx_i,
  output logic [SLICE_W-1:0] slice_o
);
  logic [SLICE_W-1:0] slices [N_SLICE];

  for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
    assign slices[k] = vec_i[k*SLICE_W +: SLICE_W];
  end

  always_comb begin
    slice_o = '0;
    for (int k = 0; k < N_SLICE; k++) begin
      if (idx_i == CNT_W'(k)) slice_o = slices[k];
    end
  end
endmodule

// File: rtl/slice_adder.sv
module slice_adder #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
endmodule

// File: rtl/slice_seq.sv
module slice_seq
  import iter_add_pkg::*;
#(
  parameter int N_SLICE = 4,
  parameter int CNT_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             run_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SLICE - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] idx_q;
  logic             done_q;

  assign run_o    = (state_q == ST_RUN);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_o   = run_o && (idx_q == LAST_IDX);
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
        end
        ST_RUN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(last_o));
  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> idx_o <= LAST_IDX);
  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last_o) |=> (run_o && idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/iter_adder.sv
module iter_adder #(
  parameter int OP_W    = 32,
  parameter int SLICE_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [OP_W-1:0] result_o,
  output logic            carry_o,
  output logic            done_o
);
  localparam int N_SLICE = OP_W / SLICE_W;
  localparam int CNT_W   = (N_SLICE > 1) ? $clog2(N_SLICE) : 1;

  logic [OP_W-1:0]    a_q, b_q, result_q;
  logic               carry_q;
  logic               accept, run, last;
  logic [CNT_W-1:0]   idx;
  logic [SLICE_W-1:0] a_sl, b_sl, sum_sl;
  logic               cout_sl;

  slice_seq #(.N_SLICE(N_SLICE), .CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .run_o    (run),
    .last_o   (last),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  slice_mux #(.OP_W(OP_W), .SLICE_W(SLICE_W), .N_SLICE(N_SLICE), .CNT_W(CNT_W)) u_mux_a (
    .vec_i (a_q), .idx_i (idx), .slice_o (a_sl)
  );

  slice_mux #(.OP_W(OP_W), .SLICE_W(SLICE_W), .N_SLICE(N_SLICE), .CNT_W(CNT_W)) u_mux_b (
    .vec_i (b_q), .idx_i (idx), .slice_o (b_sl)
  );

  slice_adder #(.SLICE_W(SLICE_W)) u_add (
    .a_i (a_sl), .b_i (b_sl), .cin_i (carry_q), .sum_o (sum_sl), .cout_o (cout_sl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
    end else if (accept) begin
      a_q     <= a_i;
      b_q     <= b_i;
      carry_q <= 1'b0;  // lowest slice sees no carry-in
    end else if (run) begin
      carry_q <= cout_sl;
    end
  end

  // result assembly: only the active slice is written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
    end else if (run) begin
      for (int k = 0; k < N_SLICE; k++) begin
        if (idx == CNT_W'(k)) result_q[k*SLICE_W +: SLICE_W] <= sum_sl;
      end
    end
  end

  assign result_o = result_q;
  assign carry_o  = carry_q;

  // R3
  first_cin_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && idx == '0) |-> !carry_q);
  // R6
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> ($stable(a_q) && $stable(b_q)));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !start_i) |=> ($stable(result_o) && $stable(carry_o)));
  // R2
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> done_o);
endmodule

// File: tb/iter_adder_tb.sv
module iter_adder_tb;
  localparam int OP_W    = 32;
  localparam int SLICE_W = 8;
  localparam int N_SLICE = OP_W / SLICE_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [OP_W-1:0] a = '0, b = '0;
  logic [OP_W-1:0] result;
  logic            carry, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  iter_adder #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .a_i (a), .b_i (b), .result_o (result), .carry_o (carry), .done_o (done)
  );

  task automatic chk(string req, logic [OP_W:0] act, logic [OP_W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start on next edge, check done timing, then check sum on done cycle
  task automatic run_add(string req, logic [OP_W-1:0] x, logic [OP_W-1:0] y);
    logic [OP_W:0] exp;
    exp = {1'b0, x} + {1'b0, y};
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j < N_SLICE; j++) begin
      @(negedge clk);
      chk("R2 done early", {{OP_W{1'b0}}, done}, '0);
    end
    @(negedge clk);
    chk("R2 done pulse", {{OP_W{1'b0}}, done}, {{OP_W{1'b0}}, 1'b1});
    chk(req, {carry, result}, exp);
    @(negedge clk);
    chk("R2 done falls", {{OP_W{1'b0}}, done}, '0);
  endtask

  task automatic t_reset();
    chk("R7 reset result", {carry, result}, '0);
    chk("R7 reset done", {{OP_W{1'b0}}, done}, '0);
  endtask

  task automatic t_vectors();
    run_add("R1 zero", 32'h0, 32'h0);
    run_add("R1 mixed", 32'h1234_5678, 32'h8765_4321);
    run_add("R1 pattern", 32'hA5A5_0F0F, 32'h5A5A_F0F1);
    run_add("R1 max", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_carry_chain();
    run_add("R4 one boundary", 32'h0000_00FF, 32'h1);
    run_add("R4 three boundaries", 32'h00FF_FFFF, 32'h1);
    run_add("R4 full ripple", 32'hFFFF_FFFF, 32'h1);
  endtask

  task automatic t_first_cin();
    run_add("R3 setup carry", 32'hFFFF_FFFF, 32'h1);
    run_add("R3 no stale carry", 32'h0, 32'h0);
    run_add("R3 low slice", 32'h0000_00FF, 32'h0);
  endtask

  task automatic t_midway();
    logic [OP_W-1:0] prev, nsum, mix;
    run_add("R5 setup", 32'h0000_00FF, 32'h0);
    prev = 32'h0000_00FF;
    nsum = 32'h1111_1111 + 32'h2222_2222;
    @(negedge clk);
    a = 32'h1111_1111; b = 32'h2222_2222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= N_SLICE; j++) begin
      @(negedge clk);
      mix = prev;
      for (int k = 0; k < j; k++) mix[k*SLICE_W +: SLICE_W] = nsum[k*SLICE_W +: SLICE_W];
      chk("R5 partial result", {1'b0, result}, {1'b0, mix});
    end
    @(negedge clk);
  endtask

  task automatic t_busy();
    logic [OP_W:0] exp;
    exp = {1'b0, 32'h0101_0101} + {1'b0, 32'h0202_0202};
    @(negedge clk);
    a = 32'h0101_0101; b = 32'h0202_0202; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    chk("R6 no done mid", {{OP_W{1'b0}}, done}, '0);
    @(negedge clk);
    start = 1'b0;
    chk("R6 no done mid", {{OP_W{1'b0}}, done}, '0);
    @(negedge clk);
    chk("R6 done on time", {{OP_W{1'b0}}, done}, {{OP_W{1'b0}}, 1'b1});
    chk("R6 own operands", {carry, result}, exp);
    for (int j = 0; j < N_SLICE + 2; j++) begin
      @(negedge clk);
      chk("R6 no extra done", {{OP_W{1'b0}}, done}, '0);
    end
  endtask

  task automatic t_hold();
    logic [OP_W:0] exp;
    exp = {1'b0, 32'hF000_0000} + {1'b0, 32'h1000_0003};
    run_add("R8 setup", 32'hF000_0000, 32'h1000_0003);
    a = 32'h1234_4321; b = 32'hDEAD_0001;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R8 hold", {carry, result}, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_vectors();
    t_carry_chain();
    t_first_cin();
    t_midway();
    t_busy();
    t_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule